// File: doc/BRIEF.md
# Thread Priority Interrupt Steering Unit

This unit sits beside the thread scheduler of a small multithreaded core and does two jobs. First, it picks a target for each arriving external interrupt. Of all threads currently eligible to take an interrupt, it chooses the one running the least important work, which is the one with the numerically largest priority. It then signals that thread with a one-cycle, one-hot grant. A request that arrives while no thread is eligible is held until some thread becomes eligible.

Second, it helps a guest scheduler decide when to preempt. Software programs a best-waiting priority, which is the priority of the most important task that is ready but not running, and sets a scheduler enable bit. While the unit is enabled, it compares every thread's running priority against the best-waiting value. When any running thread is strictly worse, it pulses a reschedule interrupt. In the same edge it reloads the best-waiting register to all ones, so the interrupt does not fire again until software writes a new value.

Top module: `prio_steer_unit`

## Requirements
- R1: Priorities are PRIO_W-bit values (9 by default), and a larger value means less important. An interrupt is granted to the eligible thread with the largest priority. Grant bit i selects thread i.
- R2: When several eligible threads share the largest priority, the lowest-numbered one is granted.
- R3: irqGrant is registered. It is high for exactly one cycle, on the clock edge that ends the first cycle in which a request is live and at least one thread is eligible. irqGrant is otherwise zero and never has more than one bit set.
- R4: A request seen while no thread is eligible stays pending and raises no grant. Further requests while it is pending merge into it. A single grant is issued on the edge that ends the first cycle in which a thread is eligible.
- R5: After reset, irqGrant and reschedIrq are 0, the scheduler enable is 0, and best-waiting holds 0x1ff (all ones).
- R6: A write with cfgWrEn high loads cfgWrData into the scheduler enable. While that enable is 0, reschedIrq stays 0 and best-waiting is not reloaded.
- R7: While enabled, reschedIrq rises on the edge that ends the first cycle in which some thread's priority is strictly greater than best-waiting. A priority equal to best-waiting does not fire.
- R8: On the edge that raises reschedIrq, best-waiting is reloaded to all ones. As a result, no further reschedule fires until software writes a new value.
- R9: A best-waiting write (bestWrEn) in the same cycle as a reschedule firing still produces the pulse, but the written value is kept instead of the reload value.
- R10: Interrupt steering and the reschedule comparison are independent. A grant and a reschedule pulse can appear on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| threadPrio | input | NUM_THREADS*PRIO_W | Running priority of each thread, thread i at bits [i*PRIO_W +: PRIO_W] |
| threadEligible | input | NUM_THREADS | Thread i may take an interrupt |
| irqReq | input | 1 | External interrupt arrival strobe |
| irqGrant | output | NUM_THREADS | One-hot, one-cycle grant to the chosen thread |
| cfgWrEn | input | 1 | Write strobe for the scheduler enable |
| cfgWrData | input | 1 | New scheduler enable value |
| bestWrEn | input | 1 | Write strobe for the best-waiting priority |
| bestWrData | input | PRIO_W | New best-waiting priority |
| reschedIrq | output | 1 | One-cycle reschedule interrupt |

## Verification
Two kinds of events can land on the same clock edge. One is a software write to best-waiting arriving in the very cycle a reschedule fires. To provoke it, the bench makes a thread worse than a freshly written best-waiting value and issues a second write in the next cycle. It then requires the pulse to appear and checks that the second value survived, by raising a thread just above that value and expecting another pulse. The other is an interrupt arriving in the same cycle a thread becomes worse than best-waiting. The bench requires both the correct grant and the reschedule pulse on the same edge.

// File: rtl/psu_pkg.sv
package psu_pkg;

  // Strobes issued by the control half to the datapath each cycle.
  typedef struct packed {
    logic grantFire;    // capture the selected thread into irqGrant
    logic reschedFire;  // raise reschedIrq on this edge
    logic bestReload;   // reload best-waiting to all ones (writes win)
  } psuStrobe_t;

endpackage

// File: rtl/psu_control.sv
module psu_control
  import psu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       irqReq,
  input  logic       anyEligible,
  input  logic       anyWorse,
  output psuStrobe_t strb
);

  logic pendingQ;
  logic reqLive;

  // A request is live on arrival or while one is being held.
  assign reqLive = irqReq | pendingQ;

  always_comb begin
    strb.grantFire   = reqLive & anyEligible;
    strb.reschedFire = anyWorse;
    strb.bestReload  = anyWorse;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendingQ <= 1'b0;
    end else begin
      pendingQ <= reqLive & ~anyEligible;
    end
  end

endmodule

// File: rtl/psu_datapath.sv
module psu_datapath
  import psu_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int PRIO_W      = 9
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_THREADS*PRIO_W-1:0] threadPrio,
  input  logic [NUM_THREADS-1:0]        threadEligible,
  input  logic                          cfgWrEn,
  input  logic                          cfgWrData,
  input  logic                          bestWrEn,
  input  logic [PRIO_W-1:0]             bestWrData,
  input  psuStrobe_t                    strb,
  output logic                          anyEligible,
  output logic                          anyWorse,
  output logic [NUM_THREADS-1:0]        irqGrant,
  output logic                          reschedIrq
);

  localparam int IDX_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1;
  localparam logic [PRIO_W-1:0] PRIO_IDLE = {PRIO_W{1'b1}};

  logic [PRIO_W-1:0]      prioArr [NUM_THREADS];
  logic [NUM_THREADS-1:0] worseVec;
  logic [PRIO_W-1:0]      bestWaitQ;
  logic                   schedEnQ;

  logic [IDX_W-1:0]       selIdx;
  logic [PRIO_W-1:0]      selPrio;
  logic                   selFound;
  logic [NUM_THREADS-1:0] selOneHot;

  // Per-thread unpack and compare against best-waiting.
  for (genvar g = 0; g < NUM_THREADS; g++) begin : g_thread
    assign prioArr[g]  = threadPrio[g*PRIO_W +: PRIO_W];
    assign worseVec[g] = prioArr[g] > bestWaitQ;
  end

  assign anyWorse = schedEnQ & (|worseVec);

  // Worst eligible priority; strict compare keeps the lowest index on ties.
  always_comb begin
    selFound = 1'b0;
    selIdx   = '0;
    selPrio  = '0;
    for (int i = 0; i < NUM_THREADS; i++) begin
      if (threadEligible[i] && (!selFound || prioArr[i] > selPrio)) begin
        selFound = 1'b1;
        selIdx   = IDX_W'(i);
        selPrio  = prioArr[i];
      end
    end
  end

  assign anyEligible = selFound;
  assign selOneHot   = NUM_THREADS'(1) << selIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqGrant   <= '0;
      reschedIrq <= 1'b0;
      schedEnQ   <= 1'b0;
      bestWaitQ  <= PRIO_IDLE;
    end else begin
      irqGrant   <= strb.grantFire ? selOneHot : '0;
      reschedIrq <= strb.reschedFire;
      if (cfgWrEn) begin
        schedEnQ <= cfgWrData;
      end
      if (bestWrEn) begin
        bestWaitQ <= bestWrData;
      end else if (strb.bestReload) begin
        bestWaitQ <= PRIO_IDLE;
      end
    end
  end

endmodule

// File: rtl/prio_steer_unit.sv
module prio_steer_unit
  import psu_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int PRIO_W      = 9
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_THREADS*PRIO_W-1:0] threadPrio,
  input  logic [NUM_THREADS-1:0]        threadEligible,
  input  logic                          irqReq,
  output logic [NUM_THREADS-1:0]        irqGrant,
  input  logic                          cfgWrEn,
  input  logic                          cfgWrData,
  input  logic                          bestWrEn,
  input  logic [PRIO_W-1:0]             bestWrData,
  output logic                          reschedIrq
);

  psuStrobe_t strb;
  logic       anyEligible;
  logic       anyWorse;

  psu_control u_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .irqReq      (irqReq),
    .anyEligible (anyEligible),
    .anyWorse    (anyWorse),
    .strb        (strb)
  );

  psu_datapath #(
    .NUM_THREADS (NUM_THREADS),
    .PRIO_W      (PRIO_W)
  ) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .threadPrio     (threadPrio),
    .threadEligible (threadEligible),
    .cfgWrEn        (cfgWrEn),
    .cfgWrData      (cfgWrData),
    .bestWrEn       (bestWrEn),
    .bestWrData     (bestWrData),
    .strb           (strb),
    .anyEligible    (anyEligible),
    .anyWorse       (anyWorse),
    .irqGrant       (irqGrant),
    .reschedIrq     (reschedIrq)
  );

endmodule

// File: rtl/psu_checker.sv
module psu_checker #(
  parameter int NUM_THREADS = 4
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   irqReq,
  input logic [NUM_THREADS-1:0] threadEligible,
  input logic                   bestWrEn,
  input logic [NUM_THREADS-1:0] irqGrant,
  input logic                   reschedIrq
);

  // R3
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(irqGrant));

  // R1
  grant_eligible_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|irqGrant) |-> ((irqGrant & $past(threadEligible)) == irqGrant));

  // R3
  grant_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && (|threadEligible)) |=> (|irqGrant));

  // R8
  resched_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reschedIrq && !$past(bestWrEn)) |=> !reschedIrq);

endmodule

bind prio_steer_unit psu_checker #(.NUM_THREADS(NUM_THREADS)) u_chk (
  .clk            (clk),
  .rstN           (rstN),
  .irqReq         (irqReq),
  .threadEligible (threadEligible),
  .bestWrEn       (bestWrEn),
  .irqGrant       (irqGrant),
  .reschedIrq     (reschedIrq)
);

// File: tb/sim_prio_steer_unit.sv
module sim_prio_steer_unit;

  localparam int NT = 4;
  localparam int PW = 9;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [NT*PW-1:0] threadPrio = '0;
  logic [NT-1:0]  threadEligible = '0;
  logic           irqReq = 1'b0;
  logic [NT-1:0]  irqGrant;
  logic           cfgWrEn = 1'b0;
  logic           cfgWrData = 1'b0;
  logic           bestWrEn = 1'b0;
  logic [PW-1:0]  bestWrData = '0;
  logic           reschedIrq;

  int vectors = 0;
  int miscompares = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #5 clk = ~clk;

  prio_steer_unit #(.NUM_THREADS(NT), .PRIO_W(PW)) u0 (
    .clk(clk), .rstN(rstN), .threadPrio(threadPrio),
    .threadEligible(threadEligible), .irqReq(irqReq), .irqGrant(irqGrant),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData), .bestWrEn(bestWrEn),
    .bestWrData(bestWrData), .reschedIrq(reschedIrq)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chkEq(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic setPrio(int t, logic [PW-1:0] v);
    threadPrio[t*PW +: PW] = v;
  endtask

  task automatic writeBest(logic [PW-1:0] v);
    bestWrEn = 1'b1; bestWrData = v;
    tick();
    bestWrEn = 1'b0;
  endtask

  task automatic writeEn(logic v);
    cfgWrEn = 1'b1; cfgWrData = v;
    tick();
    cfgWrEn = 1'b0;
  endtask

  function automatic logic [NT-1:0] expGrant(logic [NT*PW-1:0] p, logic [NT-1:0] e);
    int best = -1;
    int idx = 0;
    for (int i = 0; i < NT; i++) begin
      int v = int'(p[i*PW +: PW]);
      if (e[i] && v > best) begin best = v; idx = i; end
    end
    return (best < 0) ? '0 : NT'(1) << idx;
  endfunction

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    // R5 reset state
    tick(); tick();
    chkEq("R5 grant in reset", int'(irqGrant), 0);
    chkEq("R5 resched in reset", int'(reschedIrq), 0);
    rstN = 1'b1;
    tick();
    chkEq("R5 grant after reset", int'(irqGrant), 0);
    // best-waiting resets to 0x1ff: enabling with all threads at 0x1ff fires nothing
    for (int t = 0; t < NT; t++) setPrio(t, 9'h1ff);
    writeEn(1'b1);
    tick();
    chkEq("R5 best-waiting reset value", int'(reschedIrq), 0);
    tick();
    chkEq("R5 best-waiting reset value hold", int'(reschedIrq), 0);
    writeEn(1'b0);

    // R1 / R2 / R3 steering sweep over every nonzero eligibility mask
    for (int m = 1; m < (1 << NT); m++) begin
      for (int k = 0; k < 8; k++) begin
        for (int t = 0; t < NT; t++) begin
          seed = seed * 32'd1103515245 + 32'd12345;
          if (k == 0)                 setPrio(t, 9'h0a0);
          else if (seed[20:19] == 2'd3) setPrio(t, 9'h1ff);
          else                        setPrio(t, PW'(seed[17:16]) << 7);
        end
        threadEligible = NT'(m);
        irqReq = 1'b1;
        tick();
        irqReq = 1'b0;
        chkEq("R1 R2 steering", int'(irqGrant), int'(expGrant(threadPrio, threadEligible)));
        tick();
        chkEq("R3 grant is one cycle", int'(irqGrant), 0);
      end
    end

    // R4 pending with no eligible thread, merged requests
    threadEligible = '0;
    for (int t = 0; t < NT; t++) setPrio(t, PW'(t));
    irqReq = 1'b1; tick(); irqReq = 1'b0;
    chkEq("R4 no grant without eligible", int'(irqGrant), 0);
    tick();
    chkEq("R4 still held", int'(irqGrant), 0);
    irqReq = 1'b1; tick(); irqReq = 1'b0;
    chkEq("R4 merged request no grant", int'(irqGrant), 0);
    threadEligible = 4'b0010;
    tick();
    chkEq("R4 pending granted", int'(irqGrant), 2);
    tick();
    chkEq("R4 merged into one grant", int'(irqGrant), 0);
    threadEligible = 4'b1111;
    tick();
    chkEq("R4 pending cleared", int'(irqGrant), 0);

    // R6 disabled: no pulse; enabling later fires
    for (int t = 0; t < NT; t++) setPrio(t, '0);
    writeBest(9'h000);
    setPrio(1, 9'h005);
    tick();
    chkEq("R6 disabled no pulse", int'(reschedIrq), 0);
    tick();
    chkEq("R6 disabled no pulse hold", int'(reschedIrq), 0);
    writeEn(1'b1);
    tick();
    chkEq("R6 enable fires", int'(reschedIrq), 1);
    // R8 no refire while condition persists
    for (int i = 0; i < 3; i++) begin
      tick();
      chkEq("R8 no refire after reload", int'(reschedIrq), 0);
    end

    // R7 / R8 threshold sweep
    for (int t = 0; t < NT; t++) begin
      for (int bi = 0; bi < 4; bi++) begin
        for (int d = -1; d <= 1; d++) begin
          int b;
          int p;
          b = (bi == 0) ? 0 : (bi == 1) ? 5 : (bi == 2) ? 9'h100 : 9'h1fe;
          p = b + d;
          if (p < 0) continue;
          for (int u = 0; u < NT; u++) setPrio(u, '0);
          writeBest(PW'(b));
          setPrio(t, PW'(p));
          tick();
          chkEq("R7 strict compare", int'(reschedIrq), (p > b) ? 1 : 0);
          tick();
          chkEq("R8 pulse ends", int'(reschedIrq), 0);
        end
      end
    end

    // R9 write collides with a firing
    for (int t = 0; t < NT; t++) setPrio(t, 9'h00a);
    tick();
    writeBest(9'h003);
    bestWrEn = 1'b1; bestWrData = 9'h100;
    tick();
    bestWrEn = 1'b0;
    chkEq("R9 pulse on collision", int'(reschedIrq), 1);
    tick();
    chkEq("R9 no refire below written value", int'(reschedIrq), 0);
    setPrio(2, 9'h101);
    tick();
    chkEq("R9 written value kept", int'(reschedIrq), 1);
    tick();

    // R10 grant and reschedule on the same edge
    for (int t = 0; t < NT; t++) setPrio(t, '0);
    writeBest(9'h010);
    threadEligible = 4'b1111;
    setPrio(2, 9'h020);
    irqReq = 1'b1;
    tick();
    irqReq = 1'b0;
    chkEq("R10 grant alongside resched", int'(irqGrant), 4);
    chkEq("R10 resched alongside grant", int'(reschedIrq), 1);
    tick();

    summary();
    $finish;
  end

endmodule